// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the device-side logic that owns the status register of a serial flash memory. It listens on an SPI port in mode 0, with the most significant bit first. It decodes three instructions: a write-enable command, a write-status command and a read-status command. Every other instruction is ignored. The SPI pins are sampled by a faster system clock. A two-flop synchronizer feeds edge detectors for chip select and the serial clock.

The register has six bits that carry meaning:

- a write-in-progress flag,
- a write-enable latch,
- three block-protect bits,
- a status-write-disable bit.

A write is committed only when all of these hold:

- the write-enable latch is set,
- no self-timed cycle is running,
- the write is not blocked by hardware protection, meaning the disable bit is set while the active-low write-protect pin is held low,
- chip select returns high exactly after the eighth data bit.

A committed write starts a busy period of a programmable number of system clocks. At the end of that period the write-enable latch clears. The protect bits are driven to other logic in the chip. Serial data out is paired with an output-enable signal, so it is high impedance whenever no status byte is being sent.

A controller `sfsr_fsm`-style state machine tracks each frame. It has these states:

- **ST_IDLE**: chip select is high.
- **ST_OPCODE**: shifting in the instruction byte.
- **ST_WRDATA**: shifting in the data byte of a status write.
- **ST_WRDONE**: eight data bits have been received and the block waits for chip select to rise.
- **ST_RDOUT**: shifting out status.
- **ST_DISCARD**: ignoring the rest of the frame.

It has these transitions:

- **frame_start**: ST_IDLE to ST_OPCODE on the falling edge of chip select.
- **op_write**: ST_OPCODE to ST_WRDATA on opcode 0x01.
- **op_read**: ST_OPCODE to ST_RDOUT on opcode 0x05.
- **op_other**: ST_OPCODE to ST_DISCARD on any other opcode, 0x06 included.
- **data_full**: ST_WRDATA to ST_WRDONE after eight data bits.
- **overrun**: ST_WRDONE to ST_DISCARD on a ninth serial clock rise.
- **frame_end**: any state to ST_IDLE on the rising edge of chip select.

Top module: `sfsr_top`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch (status bit 1) once its eighth bit has been sampled.
- R2: Opcode 0x01 followed by one data byte commits only if chip select rises after exactly eight data bits. Seven or nine bits leave the register unchanged.
- R3: A write-status frame has no effect unless the write-enable latch is already set.
- R4: When the disable bit (status bit 7) is 1 and `wp_n` is low, a write-status frame has no effect.
- R5: A committed write loads data bit 7 into status bit 7 and data bits 4..2 into status bits 4..2. Status bits 6 and 5 always read 0, and data bits 1..0 do not alter status bits 1..0.
- R6: After a commit, write-in-progress (status bit 0) reads 1 for TW_CYCLES system clocks and then 0. The write-enable latch is cleared when it falls.
- R7: While write-in-progress is 1, write-enable and write-status frames are ignored, but read-status frames are still served.
- R8: Opcode 0x05 sends the status byte MSB first, changing on the serial clock's falling edge. The byte repeats with live contents for as long as chip select stays low.
- R9: `miso_oe` is 1 only during a read-status frame after its opcode. At all other times serial out is high impedance.
- R10: After reset, the status register reads 0x00, `bp_o` and `srwd_o` are 0, and `miso_oe` is 0.
- R11: Any other opcode leaves the status register unchanged.
- R12: `bp_o` and `srwd_o` always equal status bits 4..2 and bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data out, valid when `miso_oe` is 1 |
| miso_oe | output | 1 | Output enable for `miso` |
| bp_o | output | 3 | Block-protect bits |
| srwd_o | output | 1 | Status-write-disable bit |

## Verification
The properties assume the following about the inputs:

- The serial clock and chip select are slow enough that each of their edges is seen by the synchronizer as a distinct level change.
- Write-protect is steady around the rising edge of chip select that closes a write.
- Serial data in is stable across each rising edge of the serial clock.

The stimulus holds each serial clock phase for six system clocks and changes data only while the serial clock is low. It also sets `wp_n` several clocks before a frame opens and restores it only after the busy period has ended.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_WRDATA,
        ST_WRDONE,
        ST_RDOUT,
        ST_DISCARD
    } sfsr_state_e;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRSR = 8'h01;
    localparam logic [7:0] OPC_RDSR = 8'h05;

    localparam int BYTE_W  = 8;
    localparam int BP_W    = 3;
    localparam int BITCT_W = $clog2(BYTE_W + 1);

endpackage

// File: rtl/sfsr_sync.sv
module sfsr_sync #(
    parameter int              N_SIG   = 4,
    parameter int              STAGES  = 2,
    parameter logic [N_SIG-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] din,
    output logic [N_SIG-1:0] q
);

    for (genvar g = 0; g < N_SIG; g++) begin : g_bit
        logic [STAGES-1:0] pipe;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= {STAGES{RST_VAL[g]}};
            end else begin
                pipe <= {pipe[STAGES-2:0], din[g]};
            end
        end

        assign q[g] = pipe[STAGES-1];
    end

endmodule

// File: rtl/sfsr_timer.sv
module sfsr_timer #(
    parameter int TW_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(TW_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(TW_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1));

endmodule

// File: rtl/sfsr_txser.sv
module sfsr_txser #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              shift,
    input  logic [BYTE_W-1:0] live_val,
    output logic              bit_o
);

    localparam int IDX_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sr;
    logic [IDX_W-1:0]  idx;
    logic              first;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr    <= '0;
            idx   <= '0;
            first <= 1'b0;
        end else if (load) begin
            sr    <= load_val;
            idx   <= '0;
            first <= 1'b1;
        end else if (shift) begin
            if (first) begin
                first <= 1'b0;
            end else if (idx == IDX_W'(BYTE_W - 1)) begin
                sr  <= live_val;
                idx <= '0;
            end else begin
                sr  <= {sr[BYTE_W-2:0], 1'b0};
                idx <= idx + 1'b1;
            end
        end
    end

    assign bit_o = sr[BYTE_W-1];

endmodule

// File: rtl/sfsr_top.sv
module sfsr_top
    import sfsr_pkg::*;
#(
    parameter int TW_CYCLES   = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sck,
    input  logic            mosi,
    input  logic            wp_n,
    output logic            miso,
    output logic            miso_oe,
    output logic [BP_W-1:0] bp_o,
    output logic            srwd_o
);

    // synchronized pins: {wp_n, mosi, sck, cs_n}
    logic [3:0] pins_s;
    logic       cs_s, sck_s, mosi_s, wp_s;
    logic       cs_prev, sck_prev;
    logic       cs_rise, cs_fall, sck_rise, sck_fall;

    sfsr_sync #(
        .N_SIG  (4),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({wp_n, mosi, sck, cs_n}),
        .q    (pins_s)
    );

    assign cs_s   = pins_s[0];
    assign sck_s  = pins_s[1];
    assign mosi_s = pins_s[2];
    assign wp_s   = pins_s[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_s;
            sck_prev <= sck_s;
        end
    end

    assign cs_rise  =  cs_s  & ~cs_prev;
    assign cs_fall  = ~cs_s  &  cs_prev;
    assign sck_rise =  sck_s & ~sck_prev;
    assign sck_fall = ~sck_s &  sck_prev;

    // receive path
    sfsr_state_e        state_q, state_n;
    logic [BYTE_W-1:0]  rx_sr;
    logic [BITCT_W-1:0] bit_cnt;
    logic               rx_active;
    logic               byte_done;
    logic [BYTE_W-1:0]  rx_byte;

    assign rx_active = (state_q == ST_OPCODE) || (state_q == ST_WRDATA);
    assign byte_done = rx_active && sck_rise && (bit_cnt == BITCT_W'(BYTE_W - 1));
    assign rx_byte   = {rx_sr[BYTE_W-2:0], mosi_s};

    // register state
    logic            wel;
    logic [BP_W-1:0] bp_q;
    logic            srwd_q;
    logic            wip;
    logic            tmr_done;
    logic            hw_locked;
    logic            wren_hit, rdsr_hit, commit;
    logic [BYTE_W-1:0] status;

    assign hw_locked = srwd_q & ~wp_s;
    assign wren_hit  = (state_q == ST_OPCODE) && byte_done && (rx_byte == OPC_WREN) && !wip;
    assign rdsr_hit  = (state_q == ST_OPCODE) && byte_done && (rx_byte == OPC_RDSR);
    assign commit    = (state_q == ST_WRDONE) && cs_rise && wel && !wip && !hw_locked;
    assign status    = {srwd_q, 2'b00, bp_q, wel, wip};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        if (state_q != ST_IDLE && cs_rise) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cs_fall) state_n = ST_OPCODE;
                end
                ST_OPCODE: begin
                    if (byte_done) begin
                        if (rx_byte == OPC_WRSR)      state_n = ST_WRDATA;
                        else if (rx_byte == OPC_RDSR) state_n = ST_RDOUT;
                        else                          state_n = ST_DISCARD;
                    end
                end
                ST_WRDATA: begin
                    if (byte_done) state_n = ST_WRDONE;
                end
                ST_WRDONE: begin
                    if (sck_rise) state_n = ST_DISCARD;
                end
                ST_RDOUT:   state_n = ST_RDOUT;
                ST_DISCARD: state_n = ST_DISCARD;
                default:    state_n = ST_IDLE;
            endcase
        end
    end

    // shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr   <= '0;
            bit_cnt <= '0;
        end else if (cs_fall) begin
            bit_cnt <= '0;
        end else if (rx_active && sck_rise) begin
            rx_sr   <= rx_byte;
            bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
        end
    end

    // status bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel    <= 1'b0;
            bp_q   <= '0;
            srwd_q <= 1'b0;
        end else begin
            if (tmr_done)      wel <= 1'b0;
            else if (wren_hit) wel <= 1'b1;
            if (commit) begin
                srwd_q <= rx_sr[BYTE_W-1];
                bp_q   <= rx_sr[BP_W+1:2];
            end
        end
    end

    sfsr_timer #(
        .TW_CYCLES(TW_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(commit),
        .busy (wip),
        .done (tmr_done)
    );

    sfsr_txser #(
        .BYTE_W(BYTE_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rdsr_hit),
        .load_val(status),
        .shift   ((state_q == ST_RDOUT) && sck_fall),
        .live_val(status),
        .bit_o   (miso)
    );

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miso_oe <= 1'b0;
        end else begin
            miso_oe <= (state_n == ST_RDOUT);
        end
    end

    assign bp_o   = bp_q;
    assign srwd_o = srwd_q;

endmodule

// File: rtl/sfsr_checker.sv
module sfsr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_s,
    input logic       wp_s,
    input logic       miso_oe,
    input logic [2:0] bp_o,
    input logic       srwd_o,
    input logic       wel,
    input logic       wip,
    input logic       commit
);

    AST_PROT_HELD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(bp_o) && $stable(srwd_o))); // R2

    AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel)); // R3

    AST_HPM_KEEPS_SRWD: assert property (@(posedge clk) disable iff (!rst_n)
        (srwd_o && !wp_s) |=> srwd_o); // R4

    AST_WEL_CLEAR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel); // R6

    AST_NO_WEL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wip |=> !$rose(wel)); // R7

    AST_OE_OFF_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !miso_oe); // R9

endmodule

bind sfsr_top sfsr_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_s   (cs_s),
    .wp_s   (wp_s),
    .miso_oe(miso_oe),
    .bp_o   (bp_o),
    .srwd_o (srwd_o),
    .wel    (wel),
    .wip    (wip),
    .commit (commit)
);

// File: tb/sfsr_top_tb_top.sv
module sfsr_top_tb_top;

    localparam int HP = 6;
    localparam int TW = 800;

    logic       clk = 1'b0;
    logic       rst_n, cs_n, sck, mosi, wp_n;
    logic       miso, miso_oe, srwd_o;
    logic [2:0] bp_o;
    int         n_cmp = 0;
    int         n_bad = 0;
    logic       oe_leak = 1'b0;

    always #5 clk = ~clk;

    sfsr_top #(.TW_CYCLES(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .wp_n(wp_n),
        .miso(miso), .miso_oe(miso_oe), .bp_o(bp_o), .srwd_o(srwd_o)
    );

    // {wren, wp_n, data[7:0], nbits[3:0], expected status[7:0]}
    localparam logic [21:0] VEC [8] = '{
        {1'b1, 1'b1, 8'h1C, 4'd8, 8'h1C},  // R5 normal write
        {1'b0, 1'b1, 8'h00, 4'd8, 8'h1C},  // R3 no latch
        {1'b1, 1'b1, 8'h00, 4'd7, 8'h1E},  // R2 short frame
        {1'b0, 1'b1, 8'h08, 4'd9, 8'h1E},  // R2 long frame
        {1'b0, 1'b1, 8'hE4, 4'd8, 8'h84},  // R5 bits 6,5,1,0 masked
        {1'b1, 1'b0, 8'h00, 4'd8, 8'h86},  // R4 locked
        {1'b0, 1'b1, 8'h03, 4'd8, 8'h00},  // R4 pin high, unlocked
        {1'b1, 1'b0, 8'h08, 4'd8, 8'h08}   // R4 disable bit 0, pin low
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bit_io(input logic b, input logic rd, output logic r);
        mosi = b;
        tick(HP);
        r = miso;
        if (!rd && miso_oe) oe_leak = 1'b1;
        sck = 1'b1;
        tick(HP);
        sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, input int nb);
        logic r;
        for (int i = 0; i < nb; i++) bit_io((i < 8) ? v[7-i] : 1'b0, 1'b0, r);
    endtask

    task automatic frame_open();
        cs_n = 1'b0;
        tick(HP);
    endtask

    task automatic frame_close();
        tick(HP);
        cs_n = 1'b1;
        tick(2 * HP);
    endtask

    task automatic cmd(input logic [7:0] op);
        frame_open(); send_byte(op, 8); frame_close();
    endtask

    task automatic wr_status(input logic [7:0] d, input int nb);
        frame_open(); send_byte(8'h01, 8); send_byte(d, nb); frame_close();
    endtask

    task automatic rd_status(output logic [7:0] b0, output logic [7:0] b1, input int nbytes);
        logic r;
        logic [7:0] tmp;
        b0 = 8'h00;
        b1 = 8'h00;
        frame_open();
        send_byte(8'h05, 8);
        for (int k = 0; k < nbytes; k++) begin
            for (int i = 0; i < 8; i++) begin
                bit_io(1'b0, 1'b1, r);
                tmp[7-i] = r;
            end
            if (k == 0) b0 = tmp; else b1 = tmp;
        end
        chk("R9 oe high in read", {7'd0, miso_oe}, 8'h01);
        frame_close();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] s0, s1;
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; wp_n = 1'b1;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R10 reset state
        chk("R10 bp_o", {5'd0, bp_o}, 8'h00);
        chk("R10 srwd_o", {7'd0, srwd_o}, 8'h00);
        chk("R10 miso_oe", {7'd0, miso_oe}, 8'h00);
        rd_status(s0, s1, 1);
        chk("R10 status", s0, 8'h00);

        // R1 write enable
        cmd(8'h06);
        rd_status(s0, s1, 1);
        chk("R1 latch set", s0, 8'h02);

        // table of write frames
        for (int i = 0; i < 8; i++) begin
            logic [21:0] v;
            v = VEC[i];
            wp_n = v[20];
            tick(4);
            if (v[21]) cmd(8'h06);
            wr_status(v[19:12], int'(v[11:8]));
            tick(TW + 100);
            wp_n = 1'b1;
            tick(4);
            rd_status(s0, s1, 1);
            chk($sformatf("R2/R3/R4/R5/R6 row %0d status", i), s0, v[7:0]);
            chk($sformatf("R12 row %0d pins", i), {srwd_o, 4'd0, bp_o}, {v[7], 4'd0, v[4:2]});
        end

        // R6/R7 busy period
        cmd(8'h06);
        wr_status(8'h04, 8);
        rd_status(s0, s1, 1);
        chk("R6/R7 busy read", s0, 8'h07);
        cmd(8'h06);
        wr_status(8'h10, 8);
        chk("R7 write ignored while busy", {5'd0, bp_o}, 8'h01);
        tick(TW + 100);
        rd_status(s0, s1, 1);
        chk("R6/R7 after busy", s0, 8'h04);

        // R8 repeated byte
        rd_status(s0, s1, 2);
        chk("R8 byte 0", s0, 8'h04);
        chk("R8 byte 1", s1, 8'h04);

        // R11 unknown opcode
        cmd(8'h06);
        frame_open(); send_byte(8'hAB, 8); send_byte(8'h00, 8); frame_close();
        tick(TW + 100);
        rd_status(s0, s1, 1);
        chk("R11 other opcode", s0, 8'h06);

        chk("R9 no oe outside read", {7'd0, oe_leak}, 8'h00);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule